// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block turns a group of general purpose pins into one interrupt request. Every pin has its own detection setup: it can watch either a level or a transition, a transition can be a single chosen direction or any change, and a polarity bit names which level or which direction counts. A detected event latches a sticky raw status bit. Software reads the raw status and a masked copy, chooses which sources may raise the request, and acknowledges events by writing ones to a clear register.

The pin levels arrive already synchronized to the block clock, together with a direction vector in which a 1 marks a pin driven by the chip. Transitions on such output pins are not treated as events. The register port is a simple single-cycle write strobe with an address and write data; reads are combinational from the address. The combined request is registered and follows the masked status by one clock.

Register offsets (byte addresses, word aligned): enable mask 0x00, sense select 0x04, polarity 0x08, any-edge select 0x0C, clear 0x10, raw status 0x14, masked status 0x18. Bit i of every register belongs to pin i.

Top module: `gpio_irq_detector`

## Requirements
- R1: The mask (0x00), sense (0x04), polarity (0x08) and any-edge (0x0C) registers read back the last written value; the clear register (0x10) reads as 0; raw status (0x14) and masked status (0x18) are read-only and writes to them change nothing; unmapped offsets read as 0.
- R2: After reset the mask, sense, polarity, any-edge and raw status registers read 0 and irq is 0.
- R3: With sense bit 0 and any-edge bit 0, a change of an input pin sets its raw bit at the clock edge where the new level is first sampled only if the new level equals its polarity bit; a change to the other level sets nothing.
- R4: With sense bit 0 and any-edge bit 1, both rising and falling changes of an input pin set its raw bit.
- R5: In edge mode a pin whose direction bit is 1 (output) never sets its raw bit when it changes.
- R6: With sense bit 1, the raw bit is set on every clock edge at which the sampled pin level equals its polarity bit, so a clear does not remove it while the level stays active.
- R7: Writing the clear register resets each raw bit whose write-data bit is 1; raw bits whose write-data bit is 0 keep their value; nothing else lowers a raw bit.
- R8: A clear and a new detection on the same bit at the same clock edge leave that raw bit set.
- R9: Masked status reads raw status AND mask; irq is 1 when any masked bit is 1, taken from the values one clock edge earlier (one cycle of latency after a raw or mask change).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | PINS | Synchronized pin levels |
| pin_dir | input | PINS | Pin direction, 1 = output (ignored for edge events) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | PINS | Register write data |
| bus_rdata | output | PINS | Register read data for bus_addr |
| irq | output | 1 | Combined registered interrupt request |

## Verification
The bench goes after the clear and detection collision on one bit, where a design giving the clear priority would lose an event and read 0 instead of the set bit. It checks a level source being cleared while still active, which a design treating level mode as edge-like would leave at 0, and a level source whose active level is low, which fires as soon as its sense bit is written. Transitions on output-direction pins and transitions to the wrong level are driven to catch a detector that ignores direction or polarity, and partial clear patterns catch a clear that wipes the whole register. The irq output is sampled the cycle after each mask and raw change, so a combinational or two-cycle request is seen as wrong.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register word indices (byte offset / 4)
    localparam int unsigned WORD_MASK   = 0;
    localparam int unsigned WORD_SENSE  = 1;
    localparam int unsigned WORD_POL    = 2;
    localparam int unsigned WORD_ANY    = 3;
    localparam int unsigned WORD_CLEAR  = 4;
    localparam int unsigned WORD_RAW    = 5;
    localparam int unsigned WORD_MASKED = 6;

    typedef enum logic [2:0] {
        SEL_MASK,
        SEL_SENSE,
        SEL_POL,
        SEL_ANY,
        SEL_CLEAR,
        SEL_RAW,
        SEL_MASKED,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_word(input int unsigned word);
        case (word)
            WORD_MASK:   return SEL_MASK;
            WORD_SENSE:  return SEL_SENSE;
            WORD_POL:    return SEL_POL;
            WORD_ANY:    return SEL_ANY;
            WORD_CLEAR:  return SEL_CLEAR;
            WORD_RAW:    return SEL_RAW;
            WORD_MASKED: return SEL_MASKED;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_irq_cfg_regs.sv
module gpio_irq_cfg_regs
    import gpio_irq_pkg::*;
#(
    parameter int PINS   = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic [PINS-1:0]   raw,
    output logic [PINS-1:0]   bus_rdata,
    output logic [PINS-1:0]   clr,
    output logic [PINS-1:0]   mask,
    output logic [PINS-1:0]   sense,
    output logic [PINS-1:0]   pol,
    output logic [PINS-1:0]   any_edge
);

    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic [PINS-1:0] mask;
        logic [PINS-1:0] sense;
        logic [PINS-1:0] pol;
        logic [PINS-1:0] any_edge;
    } cfg_t;

    cfg_t     cfg_d, cfg_q;
    reg_sel_e sel;

    logic [WORD_W-1:0] word;
    logic              unused_addr_lsb;

    assign word            = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign sel             = decode_word(int'(unsigned'(word)));

    always_comb begin
        cfg_d     = cfg_q;
        clr       = '0;
        bus_rdata = '0;
        if (bus_wr) begin
            case (sel)
                SEL_MASK:  cfg_d.mask     = bus_wdata;
                SEL_SENSE: cfg_d.sense    = bus_wdata;
                SEL_POL:   cfg_d.pol      = bus_wdata;
                SEL_ANY:   cfg_d.any_edge = bus_wdata;
                SEL_CLEAR: clr            = bus_wdata;
                default:   ;
            endcase
        end
        case (sel)
            SEL_MASK:   bus_rdata = cfg_q.mask;
            SEL_SENSE:  bus_rdata = cfg_q.sense;
            SEL_POL:    bus_rdata = cfg_q.pol;
            SEL_ANY:    bus_rdata = cfg_q.any_edge;
            SEL_RAW:    bus_rdata = raw;
            SEL_MASKED: bus_rdata = raw & cfg_q.mask;
            default:    bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mask     = cfg_q.mask;
    assign sense    = cfg_q.sense;
    assign pol      = cfg_q.pol;
    assign any_edge = cfg_q.any_edge;

endmodule

// File: rtl/gpio_irq_edge_detect.sv
module gpio_irq_edge_detect #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_level,
    input  logic [PINS-1:0] pin_dir,
    input  logic [PINS-1:0] sense,
    input  logic [PINS-1:0] pol,
    input  logic [PINS-1:0] any_edge,
    output logic [PINS-1:0] hit
);

    logic [PINS-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = pin_level;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        logic moved;
        logic at_pol;
        logic edge_hit;

        always_comb begin
            moved    = (pin_level[i] ^ prev_q[i]) & ~pin_dir[i];
            at_pol   = ~(pin_level[i] ^ pol[i]);
            edge_hit = moved & (any_edge[i] | at_pol);
            hit[i]   = sense[i] ? at_pol : edge_hit;
        end
    end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] hit,
    input  logic [PINS-1:0] clr,
    input  logic [PINS-1:0] mask,
    output logic [PINS-1:0] raw,
    output logic            irq
);

    typedef struct packed {
        logic [PINS-1:0] raw;
        logic            irq;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        // detection wins over a simultaneous clear
        st_d.raw = (st_q.raw & ~clr) | hit;
        st_d.irq = |(st_q.raw & mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign raw = st_q.raw;
    assign irq = st_q.irq;

endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector #(
    parameter int PINS   = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   pin_level,
    input  logic [PINS-1:0]   pin_dir,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    output logic              irq
);

    logic [PINS-1:0] raw_vec;
    logic [PINS-1:0] clr_vec;
    logic [PINS-1:0] mask_vec;
    logic [PINS-1:0] sense_vec;
    logic [PINS-1:0] pol_vec;
    logic [PINS-1:0] any_vec;
    logic [PINS-1:0] hit_vec;

    gpio_irq_cfg_regs #(
        .PINS   (PINS),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .raw       (raw_vec),
        .bus_rdata (bus_rdata),
        .clr       (clr_vec),
        .mask      (mask_vec),
        .sense     (sense_vec),
        .pol       (pol_vec),
        .any_edge  (any_vec)
    );

    gpio_irq_edge_detect #(
        .PINS (PINS)
    ) detect_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .pin_dir   (pin_dir),
        .sense     (sense_vec),
        .pol       (pol_vec),
        .any_edge  (any_vec),
        .hit       (hit_vec)
    );

    gpio_irq_status #(
        .PINS (PINS)
    ) status_i (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit_vec),
        .clr   (clr_vec),
        .mask  (mask_vec),
        .raw   (raw_vec),
        .irq   (irq)
    );

endmodule

// File: rtl/gpio_irq_detector_chk.sv
module gpio_irq_detector_chk #(
    parameter int PINS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PINS-1:0] pin_level,
    input logic [PINS-1:0] pin_dir,
    input logic [PINS-1:0] raw,
    input logic [PINS-1:0] clr,
    input logic [PINS-1:0] mask,
    input logic [PINS-1:0] sense,
    input logic [PINS-1:0] pol,
    input logic            irq
);

    // R7
    raw_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(raw) & ~raw) & ~$past(clr)) == '0));

    // R9
    irq_follows_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(raw & mask)));

    // R5
    output_pin_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((raw & ~$past(raw)) & $past(pin_dir & ~sense)) == '0));

    // R6
    level_active_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sense & ~(pin_level ^ pol)) & ~raw) == '0));

endmodule

bind gpio_irq_detector gpio_irq_detector_chk #(.PINS(PINS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_level (pin_level),
    .pin_dir   (pin_dir),
    .raw       (raw_vec),
    .clr       (clr_vec),
    .mask      (mask_vec),
    .sense     (sense_vec),
    .pol       (pol_vec),
    .irq       (irq)
);

// File: tb/gpio_irq_detector_tb_top.sv
module gpio_irq_detector_tb_top;

    localparam int PINS   = 8;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_MASK   = 5'h00;
    localparam logic [ADDR_W-1:0] A_SENSE  = 5'h04;
    localparam logic [ADDR_W-1:0] A_POL    = 5'h08;
    localparam logic [ADDR_W-1:0] A_ANY    = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 5'h10;
    localparam logic [ADDR_W-1:0] A_RAW    = 5'h14;
    localparam logic [ADDR_W-1:0] A_MASKED = 5'h18;
    localparam logic [ADDR_W-1:0] A_HOLE   = 5'h1C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PINS-1:0]   pin_level = '0;
    logic [PINS-1:0]   pin_dir = '0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [PINS-1:0]   bus_wdata = '0;
    logic [PINS-1:0]   bus_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // scoreboard queues
    logic [PINS-1:0] q_exp[$];
    bit              q_kind[$];
    string           q_tag[$];
    event            mon_ev;

    always #10 clk = ~clk;

    gpio_irq_detector #(.PINS(PINS), .ADDR_W(ADDR_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_level (pin_level),
        .pin_dir   (pin_dir),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: pops expected items and compares with the design
    initial begin
        forever begin
            @(mon_ev);
            while (q_exp.size() > 0) begin
                logic [PINS-1:0] e;
                logic [PINS-1:0] act;
                bit k;
                string t;
                e = q_exp.pop_front();
                k = q_kind.pop_front();
                t = q_tag.pop_front();
                act = k ? {{(PINS-1){1'b0}}, irq} : bus_rdata;
                checks++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", t, act, e);
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [PINS-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pins(input logic [PINS-1:0] v);
        @(negedge clk);
        pin_level = v;
        @(negedge clk);
    endtask

    task automatic pins_and_clear(input logic [PINS-1:0] v, input logic [PINS-1:0] c);
        @(negedge clk);
        pin_level = v;
        bus_wr = 1'b1; bus_addr = A_CLEAR; bus_wdata = c;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [PINS-1:0] e, input string t);
        bus_addr = a;
        #1;
        q_exp.push_back(e); q_kind.push_back(1'b0); q_tag.push_back(t);
        -> mon_ev;
        #1;
    endtask

    task automatic chk_irq(input logic e, input string t);
        #1;
        q_exp.push_back({{(PINS-1){1'b0}}, e}); q_kind.push_back(1'b1); q_tag.push_back(t);
        -> mon_ev;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // reset state
        rd(A_RAW, 8'h00, "R2 raw after reset");
        rd(A_MASKED, 8'h00, "R2 masked after reset");
        rd(A_MASK, 8'h00, "R2 mask after reset");
        chk_irq(1'b0, "R2 irq after reset");
        step();
        rd(A_SENSE, 8'h00, "R2 sense after reset");
        rd(A_POL, 8'h00, "R2 polarity after reset");
        rd(A_ANY, 8'h00, "R2 any-edge after reset");

        // register map
        wr(A_ANY, 8'hA5);
        rd(A_ANY, 8'hA5, "R1 any-edge readback");
        rd(A_CLEAR, 8'h00, "R1 clear reads zero");
        rd(A_HOLE, 8'h00, "R1 unmapped reads zero");
        wr(A_ANY, 8'h00);
        wr(A_RAW, 8'hFF);
        rd(A_RAW, 8'h00, "R1 raw write ignored");
        wr(A_MASKED, 8'hFF);
        rd(A_RAW, 8'h00, "R1 masked write ignored");

        // single-direction edge, polarity 1 on pin0
        wr(A_POL, 8'h01);
        pins(8'h01);
        rd(A_RAW, 8'h01, "R3 rising edge at polarity sets");
        wr(A_CLEAR, 8'h01);
        rd(A_RAW, 8'h00, "R7 clear bit0");
        pins(8'h00);
        rd(A_RAW, 8'h00, "R3 falling edge opposite polarity ignored");

        // any-edge on pin1 (and pin2)
        wr(A_ANY, 8'h06);
        pins(8'h02);
        rd(A_RAW, 8'h02, "R4 rising edge sets");
        wr(A_CLEAR, 8'h02);
        pins(8'h00);
        rd(A_RAW, 8'h02, "R4 falling edge sets");
        wr(A_CLEAR, 8'h02);
        rd(A_RAW, 8'h00, "R7 clear bit1");

        // output-direction pin2
        pin_dir = 8'h04;
        pins(8'h04);
        rd(A_RAW, 8'h00, "R5 output pin rise ignored");
        pins(8'h00);
        rd(A_RAW, 8'h00, "R5 output pin fall ignored");
        pin_dir = 8'h00;
        pins(8'h04);
        rd(A_RAW, 8'h04, "R5 same pin as input sets");
        wr(A_CLEAR, 8'h04);
        pins(8'h00);
        wr(A_CLEAR, 8'h04);
        rd(A_RAW, 8'h00, "R7 clear bit2");

        // partial clear
        pins(8'h03);
        rd(A_RAW, 8'h03, "R3 R4 two pins set");
        wr(A_CLEAR, 8'h01);
        rd(A_RAW, 8'h02, "R7 zero bits keep raw");
        wr(A_CLEAR, 8'h02);
        rd(A_RAW, 8'h00, "R7 second clear");

        // clear and detection collide on bit1
        pins(8'h01);
        rd(A_RAW, 8'h02, "R4 pin1 fall sets");
        pins_and_clear(8'h03, 8'h02);
        rd(A_RAW, 8'h02, "R8 detection beats clear");
        wr(A_CLEAR, 8'h02);
        rd(A_RAW, 8'h00, "R8 plain clear afterwards");

        // level mode on pin3, active high
        wr(A_POL, 8'h09);
        wr(A_SENSE, 8'h08);
        rd(A_RAW, 8'h00, "R6 inactive level no set");
        pins(8'h0B);
        rd(A_RAW, 8'h08, "R6 active level sets");
        wr(A_CLEAR, 8'h08);
        rd(A_RAW, 8'h08, "R6 clear while active re-sets");
        pins(8'h03);
        rd(A_RAW, 8'h08, "R7 sticky after level drops");
        wr(A_CLEAR, 8'h08);
        rd(A_RAW, 8'h00, "R6 clear after level drops");

        // level mode on pin4, active low (pin4 already low)
        wr(A_SENSE, 8'h18);
        rd(A_RAW, 8'h00, "R6 sense takes effect next edge");
        step();
        rd(A_RAW, 8'h10, "R6 active-low level sets");
        wr(A_CLEAR, 8'h10);
        rd(A_RAW, 8'h10, "R6 active-low clear re-sets");
        wr(A_SENSE, 8'h08);
        wr(A_CLEAR, 8'h10);
        rd(A_RAW, 8'h00, "R6 clear after sense off");

        // mask and irq timing
        pins(8'h01);
        rd(A_RAW, 8'h02, "R4 pin1 fall for irq");
        wr(A_MASK, 8'h02);
        rd(A_MASKED, 8'h02, "R9 masked status");
        chk_irq(1'b0, "R9 irq one cycle after mask");
        step();
        chk_irq(1'b1, "R9 irq asserted");
        wr(A_MASK, 8'h01);
        rd(A_MASKED, 8'h00, "R9 masked after mask change");
        chk_irq(1'b1, "R9 irq still high one cycle");
        step();
        chk_irq(1'b0, "R9 irq dropped");
        wr(A_MASK, 8'h02);
        step();
        chk_irq(1'b1, "R9 irq reasserted");
        wr(A_CLEAR, 8'h02);
        rd(A_RAW, 8'h00, "R7 clear for irq");
        chk_irq(1'b1, "R9 irq lags clear");
        step();
        chk_irq(1'b0, "R9 irq low after clear");

        step();
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule